// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register File

This block is the host-facing register file of a two-channel asynchronous serial controller. A host reaches each channel through two byte ports: a control port and a data port. Most registers sit behind an indirect pointer. A control write while the pointer is zero loads the pointer. The next control access then writes or reads the selected register, and the pointer falls back to zero afterwards.

The block keeps a bank of write registers and a set of read registers for each channel. It also holds receive and transmit interrupt state: pending flags, plus an in-service flag that only one source per channel may hold at a time. A modified vector summarises the highest-priority source in service. The line settings (parity, stop bits, character length, baud divisor and prescaler) are decoded from the write registers and driven out as plain signals for a serializer outside the block.

Received bytes and break events arrive as one-cycle strobes. Transmitted bytes leave as a one-cycle strobe with a byte. A single interrupt output is the OR of both channels' requests.

Top module: `dual_sio_regs`

## Requirements
- R1: Address bit 2 selects the channel: 0 is channel B and 1 is channel A. Address bit 1 selects the data port (1) or the control port (0). Index 0 of every per-channel port vector belongs to channel B and index 1 to channel A.
- R2: A control write made while the pointer is 0 loads the pointer from data bits 2:0. A command field (bits 5:3) of 1 also sets pointer bit 3. A control write to a non-zero register stores the byte in write register n and returns the pointer to 0. Every control read returns the read register the pointer selects and returns the pointer to 0. Read data appears one cycle after the read strobe and holds until the next read.
- R3: After reset, a channel holds W4=0x04, W11=0x08, W14=0x30, W15=0xF8, R0=0x44 and R1=0x06, with every other write register 0. The shared register 9 resets to 0xC0.
- R4: Writing register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both. Each of these also returns register 9 to 0xC0. A write with bits 7:6 = 00 is stored, and its bit 4 selects status-high vectors.
- R5: A channel requests an interrupt when W1 bit 0 is set and at least one of these holds: W1 bit 1 is set with transmit pending; W1 bits 4:3 are 01 or 10 with receive pending; W15 bit 7 is set with R0 bit 7 set. irq_o is the OR of both channels' requests.
- R6: Reading R3 through channel A gives the pending flags: 0x20 for A receive, 0x10 for A transmit, 0x04 for B receive and 0x02 for B transmit. Reading R3 through channel B gives 0.
- R7: Reading R2 through channel B gives the vector of the source in service, with priority A receive, A transmit, B receive, B transmit. With status-high clear the values are 0x0C, 0x08, 0x04 and 0x00, and 0x06 when nothing is in service. With status-high set they are 0x30, 0x10, 0x20 and 0x00, and 0x60.
- R8: Per channel, at most one of receive or transmit is in service, and only a pending source can be in service. A newly pending source becomes in service when the other is not. Control command 5 clears transmit pending and transmit in-service. Command 7 clears the source in service, checking receive first. When one source is cleared and the other is still pending, the other becomes in service.
- R9: A data write sets R0 bit 2 and R1 bit 0 and makes transmit pending. When W5 bit 3 is set, the byte appears on the channel's tx_byte_o lane with a one-cycle tx_stb_o pulse in the cycle after the write.
- R10: A strobed received byte is accepted only when W3 bit 0 is set and R0 bit 0 is clear. Acceptance sets R0 bit 0 and makes receive pending. A data read returns the held byte and clears R0 bit 0 and receive pending.
- R11: W4 bit 0 enables parity and W4 bit 1 selects even parity. W4 bits 3:2 = 11 selects two stop bits. W5 bits 6:5 = 00, 01, 10 and 11 give 5, 7, 6 and 8 data bits. The baud divisor is {W13,W12}+2. W4 bits 7:6 = 00, 01, 10 and 11 give a prescaler log2 of 0, 4, 5 and 6.
- R12: A break strobe sets R0 bit 7, which stays set until that channel is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_addr_i | input | 3 | Byte address: bit 2 selects the channel, bit 1 selects the port |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| rx_stb_i | input | 2 | Received-byte strobe per channel |
| rx_byte_i | input | 16 | Received byte per channel ([7:0] B, [15:8] A) |
| brk_stb_i | input | 2 | Break-detected strobe per channel |
| tx_stb_o | output | 2 | Transmit byte strobe per channel |
| tx_byte_o | output | 16 | Transmit byte per channel |
| irq_o | output | 1 | Combined interrupt request |
| par_en_o | output | 2 | Parity enable per channel |
| par_even_o | output | 2 | Even parity select per channel |
| two_stop_o | output | 2 | Two stop bits per channel |
| data_bits_o | output | 8 | Character length per channel (4 bits each) |
| baud_div_o | output | 34 | Baud divisor per channel (17 bits each) |
| presc_log2_o | output | 6 | Prescaler log2 per channel (3 bits each) |

## Verification
On every cycle the assertions check the in-service invariants: receive and transmit are never both in service on a channel, nothing is in service unless it is pending, and nothing is left pending without a source in service. They also check that every transmit strobe traces back to a data write on that channel, that a control read always returns the pointer to zero, that read data only changes after a read, and that an interrupt never rises without a pending or break cause. The exact vector codes, the promotion order when command 7 or a data read retires a source, the channel-selective resets through register 9, and the line-setting decode can only be shown by the bench's directed scenarios, which read the registers back through the pointer.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 16;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam int NUM_CH   = 2;
  localparam int BAUD_W   = 2 * REG_W + 1;
  localparam int DBITS_W  = 4;
  localparam int PRESC_W  = 3;

  localparam logic [PTR_W-1:0] PTR_RST_REG = PTR_W'(9);

  localparam logic [2:0] CMD_HIGH    = 3'd1;
  localparam logic [2:0] CMD_CLR_TX  = 3'd5;
  localparam logic [2:0] CMD_END_SVC = 3'd7;

  localparam logic [REG_W-1:0] R0_RST = 8'h44;
  localparam logic [REG_W-1:0] R1_RST = 8'h06;
  localparam logic [REG_W-1:0] W9_RST = 8'hC0;

  function automatic logic [REG_W-1:0] wreg_rst(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sio_chan.sv
module sio_chan
  import sio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               ctl_wr_i,
  input  logic               ctl_rd_i,
  input  logic               dat_wr_i,
  input  logic               dat_rd_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               rx_stb_i,
  input  logic [REG_W-1:0]   rx_byte_i,
  input  logic               brk_stb_i,
  output logic [PTR_W-1:0]   ptr_o,
  output logic [REG_W-1:0]   r0_o,
  output logic [REG_W-1:0]   r1_o,
  output logic [REG_W-1:0]   rx_hold_o,
  output logic [REG_W-1:0]   w1_o,
  output logic               brk_en_o,
  output logic               w9_wr_o,
  output logic               clr_tx_o,
  output logic               end_svc_o,
  output logic               rx_accept_o,
  output logic               tx_stb_o,
  output logic [REG_W-1:0]   tx_byte_o,
  output logic               par_en_o,
  output logic               par_even_o,
  output logic               two_stop_o,
  output logic [DBITS_W-1:0] data_bits_o,
  output logic [BAUD_W-1:0]  baud_div_o,
  output logic [PRESC_W-1:0] presc_log2_o
);
  logic [REG_W-1:0] wreg_q [NUM_REGS];
  logic [PTR_W-1:0] ptr_q;
  logic [REG_W-1:0] r0_q, r1_q, rx_hold_q;
  logic [2:0]       cmd;
  logic             at_base;

  assign cmd         = wdata_i[5:3];
  assign at_base     = (ptr_q == '0);
  assign w9_wr_o     = ctl_wr_i && (ptr_q == PTR_RST_REG);
  assign clr_tx_o    = ctl_wr_i && at_base && (cmd == CMD_CLR_TX);
  assign end_svc_o   = ctl_wr_i && at_base && (cmd == CMD_END_SVC);
  assign rx_accept_o = rx_stb_i && wreg_q[3][0] && !r0_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_REGS; k++) wreg_q[k] <= wreg_rst(k);
      ptr_q     <= '0;
      r0_q      <= R0_RST;
      r1_q      <= R1_RST;
      rx_hold_q <= '0;
    end else if (soft_rst_i) begin
      for (int k = 0; k < NUM_REGS; k++) wreg_q[k] <= wreg_rst(k);
      ptr_q     <= '0;
      r0_q      <= R0_RST;
      r1_q      <= R1_RST;
      rx_hold_q <= '0;
    end else begin
      if (ctl_wr_i) begin
        if (at_base) begin
          ptr_q <= {cmd == CMD_HIGH, wdata_i[2:0]};
        end else begin
          // register 9 lives in the shared block above
          if (ptr_q != PTR_RST_REG) wreg_q[ptr_q] <= wdata_i;
          ptr_q <= '0;
        end
      end else if (ctl_rd_i) begin
        ptr_q <= '0;
      end
      if (rx_accept_o) begin
        r0_q[0]   <= 1'b1;
        rx_hold_q <= rx_byte_i;
      end else if (dat_rd_i) begin
        r0_q[0] <= 1'b0;
      end
      if (brk_stb_i) r0_q[7] <= 1'b1;
      if (dat_wr_i) begin
        r0_q[2] <= 1'b1;
        r1_q[0] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_stb_o  <= 1'b0;
      tx_byte_o <= '0;
    end else begin
      tx_stb_o <= dat_wr_i && wreg_q[5][3];
      if (dat_wr_i) tx_byte_o <= wdata_i;
    end
  end

  assign ptr_o     = ptr_q;
  assign r0_o      = r0_q;
  assign r1_o      = r1_q;
  assign rx_hold_o = rx_hold_q;
  assign w1_o      = wreg_q[1];
  assign brk_en_o  = wreg_q[15][7];

  assign par_en_o   = wreg_q[4][0];
  assign par_even_o = wreg_q[4][1];
  assign two_stop_o = (wreg_q[4][3:2] == 2'b11);
  assign baud_div_o = {1'b0, wreg_q[13], wreg_q[12]} + BAUD_W'(2);

  always_comb begin
    case (wreg_q[5][6:5])
      2'b00:   data_bits_o = DBITS_W'(5);
      2'b01:   data_bits_o = DBITS_W'(7);
      2'b10:   data_bits_o = DBITS_W'(6);
      default: data_bits_o = DBITS_W'(8);
    endcase
    case (wreg_q[4][7:6])
      2'b00:   presc_log2_o = PRESC_W'(0);
      2'b01:   presc_log2_o = PRESC_W'(4);
      2'b10:   presc_log2_o = PRESC_W'(5);
      default: presc_log2_o = PRESC_W'(6);
    endcase
  end
endmodule

// File: rtl/sio_int.sv
module sio_int
  import sio_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CH-1:0]            soft_rst_i,
  input  logic [NUM_CH-1:0]            set_rx_i,
  input  logic [NUM_CH-1:0]            clr_rx_i,
  input  logic [NUM_CH-1:0]            set_tx_i,
  input  logic [NUM_CH-1:0]            clr_tx_i,
  input  logic [NUM_CH-1:0]            end_svc_i,
  input  logic [NUM_CH-1:0][REG_W-1:0] w1_i,
  input  logic [NUM_CH-1:0]            brk_en_i,
  input  logic [NUM_CH-1:0]            brk_i,
  input  logic                         stat_high_i,
  output logic [NUM_CH-1:0]            rx_pend_o,
  output logic [NUM_CH-1:0]            tx_pend_o,
  output logic [NUM_CH-1:0]            rx_svc_o,
  output logic [NUM_CH-1:0]            tx_svc_o,
  output logic [REG_W-1:0]             vector_o,
  output logic [REG_W-1:0]             pend_bits_o,
  output logic                         irq_o
);
  logic [NUM_CH-1:0] ch_irq;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic rx_q, tx_q, rxs_q, txs_q;
    logic clr_rx_e, clr_tx_e, rx_n, tx_n, rxs_keep, txs_keep, rxs_n, txs_n;

    always_comb begin
      clr_rx_e = clr_rx_i[i] || (end_svc_i[i] && rxs_q);
      clr_tx_e = clr_tx_i[i] || (end_svc_i[i] && !rxs_q && txs_q);
      rx_n     = (rx_q && !clr_rx_e) || set_rx_i[i];
      tx_n     = (tx_q && !clr_tx_e) || set_tx_i[i];
      rxs_keep = rxs_q && !clr_rx_e;
      txs_keep = txs_q && !clr_tx_e;
      // receive wins only when neither source stays in service
      rxs_n    = rx_n && (rxs_keep || !txs_keep);
      txs_n    = tx_n && !rxs_n && (txs_keep || !rxs_keep);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        {rx_q, tx_q, rxs_q, txs_q} <= '0;
      end else if (soft_rst_i[i]) begin
        {rx_q, tx_q, rxs_q, txs_q} <= '0;
      end else begin
        rx_q  <= rx_n;
        tx_q  <= tx_n;
        rxs_q <= rxs_n;
        txs_q <= txs_n;
      end
    end

    assign rx_pend_o[i] = rx_q;
    assign tx_pend_o[i] = tx_q;
    assign rx_svc_o[i]  = rxs_q;
    assign tx_svc_o[i]  = txs_q;
    assign ch_irq[i] = w1_i[i][0] &&
                       ((w1_i[i][1] && tx_q) ||
                        ((w1_i[i][4:3] == 2'b01 || w1_i[i][4:3] == 2'b10) && rx_q) ||
                        (brk_en_i[i] && brk_i[i]));
  end

  assign irq_o       = |ch_irq;
  assign pend_bits_o = {2'b00, rx_pend_o[1], tx_pend_o[1], 1'b0, rx_pend_o[0], tx_pend_o[0], 1'b0};

  // index 1 = channel A, index 0 = channel B
  always_comb begin
    if (rx_svc_o[1])      vector_o = stat_high_i ? 8'h30 : 8'h0C;
    else if (tx_svc_o[1]) vector_o = stat_high_i ? 8'h10 : 8'h08;
    else if (rx_svc_o[0]) vector_o = stat_high_i ? 8'h20 : 8'h04;
    else if (tx_svc_o[0]) vector_o = 8'h00;
    else                  vector_o = stat_high_i ? 8'h60 : 8'h06;
  end
endmodule

// File: rtl/dual_sio_regs.sv
module dual_sio_regs
  import sio_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_wr_i,
  input  logic                        bus_rd_i,
  input  logic [2:0]                  bus_addr_i,
  input  logic [REG_W-1:0]            bus_wdata_i,
  output logic [REG_W-1:0]            bus_rdata_o,
  input  logic [NUM_CH-1:0]           rx_stb_i,
  input  logic [NUM_CH*REG_W-1:0]     rx_byte_i,
  input  logic [NUM_CH-1:0]           brk_stb_i,
  output logic [NUM_CH-1:0]           tx_stb_o,
  output logic [NUM_CH*REG_W-1:0]     tx_byte_o,
  output logic                        irq_o,
  output logic [NUM_CH-1:0]           par_en_o,
  output logic [NUM_CH-1:0]           par_even_o,
  output logic [NUM_CH-1:0]           two_stop_o,
  output logic [NUM_CH*DBITS_W-1:0]   data_bits_o,
  output logic [NUM_CH*BAUD_W-1:0]    baud_div_o,
  output logic [NUM_CH*PRESC_W-1:0]   presc_log2_o
);
  localparam int CH_B = 0;
  localparam int CH_A = 1;

  logic [NUM_CH-1:0]             ctl_wr, ctl_rd, dat_wr, dat_rd;
  logic [NUM_CH-1:0][PTR_W-1:0]  ptr_q;
  logic [NUM_CH-1:0][REG_W-1:0]  r0, r1, rx_hold, w1;
  logic [NUM_CH-1:0]             brk_en, w9_wr, clr_tx, end_svc, rx_accept, soft_rst;
  logic [NUM_CH-1:0]             rx_pend, tx_pend, rx_svc, tx_svc, brk_flag;
  logic [REG_W-1:0]              vector, pend_bits, w9_q;
  logic                          sel;
  logic                          w9_any;

  assign sel    = bus_addr_i[2];
  assign w9_any = |w9_wr;
  // bit 6 of the reset code targets B, bit 7 targets A
  assign soft_rst[CH_B] = w9_any && bus_wdata_i[6];
  assign soft_rst[CH_A] = w9_any && bus_wdata_i[7];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign ctl_wr[i] = bus_wr_i && !bus_addr_i[1] && (sel == 1'(i));
    assign ctl_rd[i] = bus_rd_i && !bus_addr_i[1] && (sel == 1'(i));
    assign dat_wr[i] = bus_wr_i &&  bus_addr_i[1] && (sel == 1'(i));
    assign dat_rd[i] = bus_rd_i &&  bus_addr_i[1] && (sel == 1'(i));
    assign brk_flag[i] = r0[i][7];

    sio_chan u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .soft_rst_i   (soft_rst[i]),
      .ctl_wr_i     (ctl_wr[i]),
      .ctl_rd_i     (ctl_rd[i]),
      .dat_wr_i     (dat_wr[i]),
      .dat_rd_i     (dat_rd[i]),
      .wdata_i      (bus_wdata_i),
      .rx_stb_i     (rx_stb_i[i]),
      .rx_byte_i    (rx_byte_i[i*REG_W +: REG_W]),
      .brk_stb_i    (brk_stb_i[i]),
      .ptr_o        (ptr_q[i]),
      .r0_o         (r0[i]),
      .r1_o         (r1[i]),
      .rx_hold_o    (rx_hold[i]),
      .w1_o         (w1[i]),
      .brk_en_o     (brk_en[i]),
      .w9_wr_o      (w9_wr[i]),
      .clr_tx_o     (clr_tx[i]),
      .end_svc_o    (end_svc[i]),
      .rx_accept_o  (rx_accept[i]),
      .tx_stb_o     (tx_stb_o[i]),
      .tx_byte_o    (tx_byte_o[i*REG_W +: REG_W]),
      .par_en_o     (par_en_o[i]),
      .par_even_o   (par_even_o[i]),
      .two_stop_o   (two_stop_o[i]),
      .data_bits_o  (data_bits_o[i*DBITS_W +: DBITS_W]),
      .baud_div_o   (baud_div_o[i*BAUD_W +: BAUD_W]),
      .presc_log2_o (presc_log2_o[i*PRESC_W +: PRESC_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     w9_q <= W9_RST;
    else if (w9_any) w9_q <= (bus_wdata_i[7:6] == 2'b00) ? bus_wdata_i : W9_RST;
  end

  sio_int u_int (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst),
    .set_rx_i    (rx_accept),
    .clr_rx_i    (dat_rd),
    .set_tx_i    (dat_wr),
    .clr_tx_i    (clr_tx),
    .end_svc_i   (end_svc),
    .w1_i        (w1),
    .brk_en_i    (brk_en),
    .brk_i       (brk_flag),
    .stat_high_i (w9_q[4]),
    .rx_pend_o   (rx_pend),
    .tx_pend_o   (tx_pend),
    .rx_svc_o    (rx_svc),
    .tx_svc_o    (tx_svc),
    .vector_o    (vector),
    .pend_bits_o (pend_bits),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      if (bus_addr_i[1]) begin
        bus_rdata_o <= rx_hold[sel];
      end else begin
        case (ptr_q[sel])
          PTR_W'(0): bus_rdata_o <= r0[sel];
          PTR_W'(1): bus_rdata_o <= r1[sel];
          PTR_W'(2): bus_rdata_o <= (sel == 1'(CH_B)) ? vector : '0;
          PTR_W'(3): bus_rdata_o <= (sel == 1'(CH_A)) ? pend_bits : '0;
          default:   bus_rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_sio_regs_chk.sv
module dual_sio_regs_chk
  import sio_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       bus_wr_i,
  input logic                       bus_rd_i,
  input logic [2:0]                 bus_addr_i,
  input logic [REG_W-1:0]           bus_rdata_o,
  input logic [NUM_CH-1:0]          tx_stb_o,
  input logic                       irq_o,
  input logic [NUM_CH-1:0][PTR_W-1:0] ptr_q,
  input logic [NUM_CH-1:0]          rx_pend,
  input logic [NUM_CH-1:0]          tx_pend,
  input logic [NUM_CH-1:0]          rx_svc,
  input logic [NUM_CH-1:0]          tx_svc,
  input logic [NUM_CH-1:0]          brk_flag
);
  AST_SVC_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_svc & tx_svc) == '0); // R8
  AST_SVC_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_svc & ~rx_pend) | (tx_svc & ~tx_pend)) == '0); // R8
  AST_PEND_HAS_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_pend | tx_pend) & ~(rx_svc | tx_svc)) == '0); // R8
  AST_TX_A_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stb_o[1] |-> $past(bus_wr_i && bus_addr_i[2:1] == 2'b11)); // R9
  AST_TX_B_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stb_o[0] |-> $past(bus_wr_i && bus_addr_i[2:1] == 2'b01)); // R9
  AST_PTR_A_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_rd_i && bus_addr_i[2:1] == 2'b10) |-> ptr_q[1] == '0); // R2
  AST_PTR_B_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_rd_i && bus_addr_i[2:1] == 2'b00) |-> ptr_q[0] == '0); // R2
  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_rd_i) |-> $stable(bus_rdata_o)); // R2
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|rx_pend || |tx_pend || |brk_flag)); // R5
endmodule

bind dual_sio_regs dual_sio_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .tx_stb_o    (tx_stb_o),
  .irq_o       (irq_o),
  .ptr_q       (ptr_q),
  .rx_pend     (rx_pend),
  .tx_pend     (tx_pend),
  .rx_svc      (rx_svc),
  .tx_svc      (tx_svc),
  .brk_flag    (brk_flag)
);

// File: tb/dual_sio_regs_tb.sv
`timescale 1ns/1ps
module dual_sio_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [1:0]  rx_stb_i = '0;
  logic [15:0] rx_byte_i = '0;
  logic [1:0]  brk_stb_i = '0;
  logic [1:0]  tx_stb_o;
  logic [15:0] tx_byte_o;
  logic        irq_o;
  logic [1:0]  par_en_o, par_even_o, two_stop_o;
  logic [7:0]  data_bits_o;
  logic [33:0] baud_div_o;
  logic [5:0]  presc_log2_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dual_sio_regs u_dut (
    .clk_i, .rst_ni, .bus_wr_i, .bus_rd_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .rx_stb_i, .rx_byte_i, .brk_stb_i, .tx_stb_o, .tx_byte_o, .irq_o,
    .par_en_o, .par_even_o, .two_stop_o, .data_bits_o, .baud_div_o, .presc_log2_o
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i); bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i); bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk_i); bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk_i); bus_rd_i = 1'b0; v = bus_rdata_o;
  endtask

  // ch: 1 = A (offset 4), 0 = B (offset 0)
  task automatic wreg(input bit ch, input int n, input logic [7:0] v);
    wr({ch, 2'b00}, (n >= 8) ? 8'(8'h08 | (n - 8)) : 8'(n));
    wr({ch, 2'b00}, v);
  endtask

  task automatic rreg(input bit ch, input int n, output logic [7:0] v);
    if (n >= 8) wr({ch, 2'b00}, 8'(8'h08 | (n - 8)));
    else if (n != 0) wr({ch, 2'b00}, 8'(n));
    rd({ch, 2'b00}, v);
  endtask

  task automatic rx_byte(input bit ch, input logic [7:0] b);
    @(negedge clk_i); rx_stb_i[ch] = 1'b1; rx_byte_i[ch*8 +: 8] = b;
    @(negedge clk_i); rx_stb_i = '0;
  endtask

  task automatic brk(input bit ch);
    @(negedge clk_i); brk_stb_i[ch] = 1'b1;
    @(negedge clk_i); brk_stb_i = '0;
  endtask

  task automatic full_reset();
    wreg(1'b1, 9, 8'hC0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rreg(1'b1, 0, v); check("R3 A R0", v, 8'h44);
    rreg(1'b0, 1, v); check("R3 B R1", v, 8'h06);
    rreg(1'b0, 2, v); check("R7 idle vector", v, 8'h06);
    rreg(1'b1, 3, v); check("R6 no pending", v, 8'h00);
    check("R3 irq", irq_o, 0);
    check("R3 data bits", data_bits_o, 8'h55);
    check("R3 baud div", baud_div_o, {17'd2, 17'd2});
    check("R3 presc", presc_log2_o, 0);
    check("R3 parity/stop", {par_en_o, two_stop_o}, 0);
  endtask

  task automatic t_pointer();
    logic [7:0] v;
    full_reset();
    wr(3'd4, 8'h04);
    wr(3'd4, 8'hCF);
    rd(3'd4, v); check("R2 ptr back to 0 after write", v, 8'h44);
    check("R2 W4 stored A", {par_en_o[1], par_even_o[1], two_stop_o[1], presc_log2_o[5:3]}, {3'b111, 3'd6});
    wreg(1'b1, 12, 8'h34);
    wreg(1'b1, 13, 8'h12);
    check("R2 high-bank pointer W12/W13", baud_div_o[33:17], 17'h1236);
    rreg(1'b1, 1, v); check("R2 R1 read", v, 8'h06);
    rd(3'd4, v); check("R2 ptr back to 0 after read", v, 8'h44);
  endtask

  task automatic t_line();
    wreg(1'b0, 4, 8'h41);
    check("R11 W4=41", {par_en_o[0], par_even_o[0], two_stop_o[0], presc_log2_o[2:0]}, {3'b100, 3'd4});
    wreg(1'b0, 4, 8'h88);
    check("R11 W4=88", {par_en_o[0], par_even_o[0], two_stop_o[0], presc_log2_o[2:0]}, {3'b000, 3'd5});
    wreg(1'b0, 5, 8'h20); check("R11 7 bits", data_bits_o[3:0], 7);
    wreg(1'b0, 5, 8'h40); check("R11 6 bits", data_bits_o[3:0], 6);
    wreg(1'b0, 5, 8'h60); check("R11 8 bits", data_bits_o[3:0], 8);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    full_reset();
    wreg(1'b1, 5, 8'h08);
    wr(3'd6, 8'h5A);
    check("R9 R1 tx strobe on A lane", tx_stb_o, 2'b10);
    check("R9 tx byte", tx_byte_o[15:8], 8'h5A);
    @(negedge clk_i); check("R9 strobe one cycle", tx_stb_o, 2'b00);
    rreg(1'b1, 1, v); check("R9 R1 bit0", v, 8'h07);
    wr(3'd2, 8'h33);
    check("R9 no tx when W5 bit3 clear", tx_stb_o, 2'b00);
    rreg(1'b1, 3, v); check("R6 A tx + B tx pending", v, 8'h12);
    rreg(1'b0, 3, v); check("R6 R3 via B is 0", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    full_reset();
    wreg(1'b1, 1, 8'h02);
    wr(3'd6, 8'h00);
    check("R5 no master enable", irq_o, 0);
    wreg(1'b1, 1, 8'h03); check("R5 tx irq", irq_o, 1);
    wreg(1'b1, 1, 8'h01); check("R5 tx irq masked", irq_o, 0);
    wreg(1'b0, 3, 8'h01);
    wreg(1'b0, 1, 8'h19);
    rx_byte(1'b0, 8'h44);
    check("R5 rx mode 11 no irq", irq_o, 0);
    wreg(1'b0, 1, 8'h09); check("R5 rx mode 01", irq_o, 1);
    wreg(1'b0, 1, 8'h11); check("R5 rx mode 10", irq_o, 1);
    rd(3'd2, v); check("R10 data read clears rx irq", irq_o, 0);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    full_reset();
    rx_byte(1'b0, 8'hA5);
    rreg(1'b0, 0, v); check("R10 rx disabled ignored", v, 8'h44);
    wreg(1'b0, 3, 8'h01);
    rx_byte(1'b0, 8'hA5);
    rreg(1'b0, 0, v); check("R10 R0 bit0 set", v, 8'h45);
    rreg(1'b1, 3, v); check("R6 B rx pending", v, 8'h04);
    rreg(1'b0, 2, v); check("R7 B rx vector", v, 8'h04);
    rx_byte(1'b0, 8'h11);
    rd(3'd2, v); check("R10 second byte dropped", v, 8'hA5);
    rreg(1'b0, 0, v); check("R10 R0 bit0 cleared", v, 8'h44);
    rreg(1'b1, 3, v); check("R10 rx pending cleared", v, 8'h00);
  endtask

  task automatic t_service();
    logic [7:0] v;
    full_reset();
    wr(3'd6, 8'h00);
    rreg(1'b0, 2, v); check("R7 A tx vector", v, 8'h08);
    wreg(1'b1, 3, 8'h01);
    rx_byte(1'b1, 8'h77);
    rreg(1'b1, 3, v); check("R6 A rx+tx pending", v, 8'h30);
    rreg(1'b0, 2, v); check("R8 rx waits while tx in service", v, 8'h08);
    wr(3'd4, 8'h38);
    rreg(1'b1, 3, v); check("R8 cmd7 clears tx", v, 8'h20);
    rreg(1'b0, 2, v); check("R8 rx promoted", v, 8'h0C);
    wreg(1'b1, 9, 8'h10);
    rreg(1'b0, 2, v); check("R4 R7 status-high A rx", v, 8'h30);
    wr(3'd2, 8'h00);
    rreg(1'b0, 2, v); check("R7 A rx beats B tx", v, 8'h30);
    rreg(1'b1, 3, v); check("R6 A rx + B tx", v, 8'h22);
    rd(3'd6, v); check("R10 rx byte A", v, 8'h77);
    rreg(1'b0, 2, v); check("R7 B tx vector high", v, 8'h00);
    wr(3'd0, 8'h28);
    rreg(1'b0, 2, v); check("R8 cmd5 clears B tx", v, 8'h60);
    wr(3'd6, 8'h00);
    rreg(1'b0, 2, v); check("R7 A tx vector high", v, 8'h10);
    wr(3'd4, 8'h38);
    wreg(1'b0, 3, 8'h01);
    rx_byte(1'b0, 8'h01);
    rreg(1'b0, 2, v); check("R7 B rx vector high", v, 8'h20);
  endtask

  task automatic t_chan_reset();
    logic [7:0] v;
    full_reset();
    wreg(1'b0, 5, 8'h68);
    wreg(1'b1, 5, 8'h60);
    wr(3'd2, 8'h00);
    wreg(1'b0, 9, 8'h40);
    check("R4 B reset only", data_bits_o, {4'd8, 4'd5});
    rreg(1'b1, 3, v); check("R4 B pending cleared", v, 8'h00);
    rreg(1'b0, 1, v); check("R4 B R1 reset", v, 8'h06);
    wreg(1'b0, 9, 8'h80);
    check("R4 A reset", data_bits_o, 8'h55);
    wreg(1'b1, 9, 8'h10);
    wreg(1'b1, 9, 8'hC0);
    wr(3'd6, 8'h00);
    rreg(1'b0, 2, v); check("R4 W9 back to C0", v, 8'h08);
  endtask

  task automatic t_break();
    logic [7:0] v;
    full_reset();
    wreg(1'b0, 1, 8'h01);
    check("R5 no break irq yet", irq_o, 0);
    brk(1'b0);
    check("R5 R12 break irq", irq_o, 1);
    rreg(1'b0, 0, v); check("R12 R0 bit7", v, 8'hC4);
    wreg(1'b0, 15, 8'h00);
    check("R5 break irq masked by W15", irq_o, 0);
    rreg(1'b0, 0, v); check("R12 break sticky", v, 8'hC4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pointer();
    t_line();
    t_tx();
    t_irq();
    t_rx();
    t_service();
    t_chan_reset();
    t_break();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule